// File: doc/BRIEF.md
# Low-Power Mode Wake-Up Controller

This block sits beside a small processor core and holds one 8-bit control and status register. A write can request one of two low-power states (sleep or suspend), clear every wake-up flag at once, and load the enables for four wake-up sources: real-time-clock oscillator failure, real-time-clock alarm, port match, and comparator rising edge. A fifth source, a glitch seen on the reset pin, only records a flag and has no enable. On a read, the register returns the five sticky flags. The three command bits always read as zero.

Entry into a low-power state is refused while any flag is set. The enables do not survive a low-power episode, so software loads the enables and the mode request in the same write. While the block is in a low-power state, an event from an enabled source returns it to run and pulses the wake output. An event from a disabled source only records its flag. For two clocks after a wake from suspend, every flag bit reads as zero. The clock gating itself is not part of this block. It is driven from the mode outputs.

Top module: `lpwr_wake_ctrl`

## Requirements
- R1: After reset, `cfg_rdata` is 0x00, `pm_mode` is 0 (run), and `wake_pulse`, `sleep_req` and `suspend_req` are all 0.
- R2: Register bits 7 (sleep), 6 (suspend) and 5 (clear) are command bits and always read as 0.
- R3: An accepted write with bit 5 set clears all five flags. An event in the same cycle as the clear wins, and its flag ends up set.
- R4: A pulse on `pin_glitch` sets flag bit 4. Writing bit 4 has no effect on that flag. Only the clear command resets it.
- R5: Events set sticky flags at these positions: comparator rising edge at bit 0, port match at bit 1, alarm at bit 2, oscillator failure at bit 3. The comparator sets its flag on a 0-to-1 transition of `cmp_level`, not on its level.
- R6: A sleep or suspend request written while any flag is 1 is ignored, and the mode stays run.
- R7: An accepted write with bit 7 set enters sleep (`pm_mode`=2, `sleep_req`=1). With bit 6 set it enters suspend (`pm_mode`=1, `suspend_req`=1). When both bits are set, sleep wins. The new mode is visible one clock after the write.
- R8: Each accepted write loads the four source enables from bits 3..0 (bit n enables the source whose flag is bit n). A wake clears all enables.
- R9: In sleep or suspend, an event from an enabled source returns the mode to run and raises `wake_pulse` for exactly one clock, both one clock after the event. The event's flag is set in that same clock.
- R10: In sleep or suspend, an event from a disabled source sets its flag but causes no wake, and the mode is unchanged.
- R11: After a wake from suspend, flag bits read as 0 for two clocks: the clock in which `wake_pulse` is high and the clock after it. After a wake from sleep, the flags read back without masking.
- R12: Writes made while the mode is not run are ignored, including clear commands and mode requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data (flags) |
| pin_glitch | input | 1 | Pulse from the reset-pin glitch detector |
| osc_fail_evt | input | 1 | Real-time-clock oscillator failure event |
| alarm_evt | input | 1 | Real-time-clock alarm event |
| port_match_evt | input | 1 | Port match event |
| cmp_level | input | 1 | Comparator output level |
| pm_mode | output | 2 | Current mode: 0 run, 1 suspend, 2 sleep |
| sleep_req | output | 1 | High while in sleep |
| suspend_req | output | 1 | High while in suspend |
| wake_pulse | output | 1 | One-clock pulse on the return to run |

## Verification
Two functions can land in the same clock: a write that clears all flags and a source event that sets one. The bench provokes this by raising the comparator level in the same cycle as a clear write. It then expects bit 0 to read as set, because a set must win over a clear. A second overlap is a mode request made in the same write as a clear while a flag is still set. The request must be refused, because the refusal is judged on the flags held before that write.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned N_SRC     = 4;            // sources with an enable
  localparam int unsigned N_FLAG    = N_SRC + 1;    // plus reset-pin flag
  localparam int unsigned BIT_SLEEP = 7;
  localparam int unsigned BIT_SUSP  = 6;
  localparam int unsigned BIT_CLR   = 5;
  localparam int unsigned BIT_PIN   = 4;

  typedef enum logic [1:0] {
    PM_RUN     = 2'd0,
    PM_SUSPEND = 2'd1,
    PM_SLEEP   = 2'd2
  } pm_mode_e;
endpackage

// File: rtl/pmu_evt_capture.sv
module pmu_evt_capture #(
  parameter int unsigned N_SRC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmp_level,
  input  logic [N_SRC-2:0]   ext_evt,    // sources 1..N_SRC-1, already pulses
  output logic [N_SRC-1:0]   evt
);
  logic cmp_q;
  logic cmp_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_q <= 1'b0;
    else        cmp_q <= cmp_level;
  end

  assign cmp_rise = cmp_level & ~cmp_q;
  assign evt[0]   = cmp_rise;

  for (genvar g = 1; g < N_SRC; g++) begin : g_ext
    assign evt[g] = ext_evt[g-1];
  end
endmodule

// File: rtl/pmu_flag_bank.sv
module pmu_flag_bank #(
  parameter int unsigned N_FLAG = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_FLAG-1:0] set_i,
  input  logic              clr_all,
  output logic [N_FLAG-1:0] flags_q
);
  logic [N_FLAG-1:0] upd_en;
  logic [N_FLAG-1:0] flags_d;

  always_comb begin
    for (int i = 0; i < N_FLAG; i++) begin
      upd_en[i]  = set_i[i] | clr_all;
      flags_d[i] = set_i[i];          // set wins over clear
    end
  end

  for (genvar g = 0; g < N_FLAG; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flags_q[g] <= 1'b0;
      else if (upd_en[g]) flags_q[g] <= flags_d[g];
    end
  end
endmodule

// File: rtl/pmu_mode_fsm.sv
module pmu_mode_fsm
  import pmu_pkg::*;
#(
  parameter int unsigned MASK_CYC = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_ok,
  input  logic     cmd_sleep,
  input  logic     cmd_susp,
  input  logic     any_flag,
  input  logic     wake_hit,
  output pm_mode_e mode_q,
  output logic     wake_q,
  output logic     mask_act
);
  localparam int unsigned MW = $clog2(MASK_CYC + 1);
  localparam logic [MW-1:0] MASK_LOAD = MW'(MASK_CYC);

  pm_mode_e      mode_d;
  logic          mode_en;
  logic          wake_d;
  logic [MW-1:0] mask_q, mask_d;
  logic          mask_en;

  always_comb begin
    mode_d = mode_q;
    wake_d = 1'b0;
    unique case (mode_q)
      PM_RUN: begin
        if (wr_ok && !any_flag) begin
          if (cmd_sleep)     mode_d = PM_SLEEP;
          else if (cmd_susp) mode_d = PM_SUSPEND;
        end
      end
      PM_SUSPEND, PM_SLEEP: begin
        if (wake_hit) begin
          mode_d = PM_RUN;
          wake_d = 1'b1;
        end
      end
      default: mode_d = PM_RUN;
    endcase
    mode_en = (mode_d != mode_q);
  end

  always_comb begin
    mask_d  = mask_q;
    mask_en = 1'b0;
    if (mode_q == PM_SUSPEND && wake_hit) begin
      mask_d  = MASK_LOAD;
      mask_en = 1'b1;
    end else if (mask_q != '0) begin
      mask_d  = mask_q - 1'b1;
      mask_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= PM_RUN;
    else if (mode_en) mode_q <= mode_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= wake_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  assign mask_act = (mask_q != '0);
endmodule

// File: rtl/lpwr_wake_ctrl.sv
module lpwr_wake_ctrl
  import pmu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       pin_glitch,
  input  logic       osc_fail_evt,
  input  logic       alarm_evt,
  input  logic       port_match_evt,
  input  logic       cmp_level,
  output logic [1:0] pm_mode,
  output logic       sleep_req,
  output logic       suspend_req,
  output logic       wake_pulse
);
  pm_mode_e          mode_q;
  logic              wr_ok;
  logic [N_SRC-1:0]  evt;
  logic [N_SRC-1:0]  en_q, en_d;
  logic              en_ld;
  logic [N_FLAG-1:0] flags_q;
  logic [N_FLAG-1:0] flag_set;
  logic              clr_all;
  logic              any_flag;
  logic              wake_hit;
  logic              mask_act;

  assign wr_ok = cfg_wr && (mode_q == PM_RUN);

  pmu_evt_capture #(.N_SRC(N_SRC)) u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_level (cmp_level),
    .ext_evt   ({osc_fail_evt, alarm_evt, port_match_evt}),
    .evt       (evt)
  );

  assign flag_set = {pin_glitch, evt};
  assign clr_all  = wr_ok && cfg_wdata[BIT_CLR];

  pmu_flag_bank #(.N_FLAG(N_FLAG)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (flag_set),
    .clr_all (clr_all),
    .flags_q (flags_q)
  );

  assign any_flag = |flags_q;
  assign wake_hit = |(evt & en_q);

  // enables: loaded on each accepted write, dropped on a wake
  always_comb begin
    en_d  = en_q;
    en_ld = 1'b0;
    if (mode_q != PM_RUN && wake_hit) begin
      en_d  = '0;
      en_ld = 1'b1;
    end else if (wr_ok) begin
      en_d  = cfg_wdata[N_SRC-1:0];
      en_ld = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ld) en_q <= en_d;
  end

  pmu_mode_fsm #(.MASK_CYC(2)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ok     (wr_ok),
    .cmd_sleep (cfg_wdata[BIT_SLEEP]),
    .cmd_susp  (cfg_wdata[BIT_SUSP]),
    .any_flag  (any_flag),
    .wake_hit  (wake_hit),
    .mode_q    (mode_q),
    .wake_q    (wake_pulse),
    .mask_act  (mask_act)
  );

  assign cfg_rdata   = {3'b000, (mask_act ? {N_FLAG{1'b0}} : flags_q)};
  assign pm_mode     = mode_q;
  assign sleep_req   = (mode_q == PM_SLEEP);
  assign suspend_req = (mode_q == PM_SUSPEND);
endmodule

// File: rtl/pmu_chk.sv
module pmu_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wr,
  input logic [7:0] cfg_wdata,
  input logic [7:0] cfg_rdata,
  input logic [1:0] pm_mode,
  input logic       wake_pulse,
  input logic [4:0] flags_q,
  input logic [3:0] en_q
);
  AST_CMD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[7:5] == 3'b000); // R2

  AST_REFUSE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_mode == 2'd0 && flags_q != 5'd0) |=> pm_mode == 2'd0); // R6

  AST_SLEEP_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_mode == 2'd0 && cfg_wr && cfg_wdata[7] && cfg_wdata[6] && flags_q == 5'd0)
      |=> pm_mode == 2'd2); // R7

  AST_WAKE_DROPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> en_q == 4'd0); // R8

  AST_WAKE_TO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> (pm_mode == 2'd0 && $past(pm_mode) != 2'd0)); // R9

  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse); // R9

  AST_SUSP_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pm_mode) == 2'd1 && pm_mode == 2'd0) |-> cfg_rdata == 8'd0); // R11

  AST_LP_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_mode != 2'd0 && cfg_wr && !wake_pulse && flags_q != 5'd0) |=> flags_q != 5'd0); // R12
endmodule

bind lpwr_wake_ctrl pmu_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_wr     (cfg_wr),
  .cfg_wdata  (cfg_wdata),
  .cfg_rdata  (cfg_rdata),
  .pm_mode    (pm_mode),
  .wake_pulse (wake_pulse),
  .flags_q    (flags_q),
  .en_q       (en_q)
);

// File: tb/lpwr_wake_ctrl_test.sv
module lpwr_wake_ctrl_test;
  logic       clk;
  logic       rst_n;
  logic       cfg_wr;
  logic [7:0] cfg_wdata;
  logic [7:0] cfg_rdata;
  logic       pin_glitch, osc_fail_evt, alarm_evt, port_match_evt, cmp_level;
  logic [1:0] pm_mode;
  logic       sleep_req, suspend_req, wake_pulse;

  int n_chk  = 0;
  int n_fail = 0;

  lpwr_wake_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .pin_glitch(pin_glitch), .osc_fail_evt(osc_fail_evt),
    .alarm_evt(alarm_evt), .port_match_evt(port_match_evt), .cmp_level(cmp_level),
    .pm_mode(pm_mode), .sleep_req(sleep_req), .suspend_req(suspend_req),
    .wake_pulse(wake_pulse)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0; cfg_wdata = 8'h00;
  endtask

  // src: 0 cmp, 1 port, 2 alarm, 3 osc, 4 pin
  task automatic pulse(input int src);
    @(negedge clk);
    case (src)
      0: cmp_level = 1'b1;
      1: port_match_evt = 1'b1;
      2: alarm_evt = 1'b1;
      3: osc_fail_evt = 1'b1;
      default: pin_glitch = 1'b1;
    endcase
    @(negedge clk);
    {cmp_level, port_match_evt, alarm_evt, osc_fail_evt, pin_glitch} = '0;
  endtask

  task automatic t_reset;
    check("R1 rdata", cfg_rdata, 8'h00);
    check("R1 mode", {6'd0, pm_mode}, 8'h00);
    check("R1 outs", {5'd0, wake_pulse, sleep_req, suspend_req}, 8'h00);
  endtask

  task automatic t_flags;
    pulse(1); check("R5 port", cfg_rdata, 8'h02);
    pulse(2); check("R5 alarm", cfg_rdata, 8'h06);
    pulse(3); check("R5 osc", cfg_rdata, 8'h0E);
    pulse(0); check("R5 cmp", cfg_rdata, 8'h0F);
    repeat (3) @(negedge clk);
    check("R5 sticky", cfg_rdata, 8'h0F);
    wr(8'hE0 & 8'h20); check("R3 clear", cfg_rdata, 8'h00);
    wr(8'h00); check("R2 cmd bits", {cfg_rdata[7:5], 5'd0}, 8'h00);
  endtask

  task automatic t_pin;
    pulse(4); check("R4 pin set", cfg_rdata, 8'h10);
    wr(8'h00); check("R4 write no effect", cfg_rdata, 8'h10);
    wr(8'h20); check("R4 clear", cfg_rdata, 8'h00);
  endtask

  task automatic t_collision;
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = 8'h20; cmp_level = 1'b1;
    @(negedge clk); cfg_wr = 1'b0; cfg_wdata = 8'h00; cmp_level = 1'b0;
    check("R3 set wins", cfg_rdata, 8'h01);
  endtask

  task automatic t_refuse;
    wr(8'hA1); // sleep + clear while flag set: refused
    check("R6 refused", {6'd0, pm_mode}, 8'h00);
    check("R6 flags cleared", cfg_rdata, 8'h00);
  endtask

  task automatic t_sleep;
    wr(8'h82);
    check("R7 sleep mode", {6'd0, pm_mode}, 8'h02);
    check("R7 sleep_req", {7'd0, sleep_req}, 8'h01);
    pulse(2);
    check("R10 no wake", {6'd0, pm_mode}, 8'h02);
    check("R10 flag set", cfg_rdata, 8'h04);
    wr(8'h20);
    check("R12 clear ignored", cfg_rdata, 8'h04);
    @(negedge clk); port_match_evt = 1'b1;
    @(negedge clk); port_match_evt = 1'b0;
    check("R9 wake", {7'd0, wake_pulse}, 8'h01);
    check("R9 run", {6'd0, pm_mode}, 8'h00);
    check("R11 sleep unmasked", cfg_rdata, 8'h06);
    @(negedge clk);
    check("R9 one pulse", {7'd0, wake_pulse}, 8'h00);
    wr(8'h20);
  endtask

  task automatic t_suspend;
    wr(8'h41);
    check("R7 suspend mode", {6'd0, pm_mode}, 8'h01);
    check("R7 suspend_req", {7'd0, suspend_req}, 8'h01);
    wr(8'h80);
    check("R12 request ignored", {6'd0, pm_mode}, 8'h01);
    pulse(3);
    check("R10 osc no wake", {6'd0, pm_mode}, 8'h01);
    @(negedge clk); cmp_level = 1'b1;
    @(negedge clk); cmp_level = 1'b0;
    check("R9 susp wake", {7'd0, wake_pulse}, 8'h01);
    check("R11 mask c1", cfg_rdata, 8'h00);
    @(negedge clk);
    check("R11 mask c2", cfg_rdata, 8'h00);
    @(negedge clk);
    check("R11 unmasked", cfg_rdata, 8'h09);
    wr(8'h20);
  endtask

  task automatic t_priority;
    wr(8'hC4);
    check("R7 sleep priority", {6'd0, pm_mode}, 8'h02);
    pulse(1);
    check("R8 port disabled", {6'd0, pm_mode}, 8'h02);
    pulse(2);
    check("R8 alarm enabled wake", {6'd0, pm_mode}, 8'h00);
    wr(8'h20);
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_wdata = 8'h00;
    {cmp_level, port_match_evt, alarm_evt, osc_fail_evt, pin_glitch} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_flags;
    t_pin;
    t_collision;
    t_refuse;
    t_sleep;
    t_suspend;
    t_priority;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule